// File: doc/BRIEF.md
# Lockable Real-Time Clock Source Selector

This block picks the time base that feeds a real-time counter. It offers three inputs: a slow crystal clock, a slow on-chip RC clock, and the fast crystal clock after a fixed divide-by-128 prescaler. All three arrive as single-cycle enable pulses in one common fast clock domain. The block's output is one registered enable stream that the counter advances on. The block also outputs a square wave with a 50% duty cycle, taken from the prescaler.

Software selects the source through a two-bit field. The first nonzero write selects the source and sets a lock at the same time. After that, further writes have no effect. Only the dedicated backup-domain reset clears the lock and the field. The ordinary system reset restarts the prescaler and the output stage, but it leaves the lock and the selection as they were.

Top module: `rtcsrc_select`

## Requirements
- R1: `bkp_rst` sets `sel_rd` to 00 and clears `lock_rd` on the next cycle. A `rst` pulse on its own leaves `sel_rd` and `lock_rd` unchanged.
- R2: When the block is unlocked, a write (`sel_wr`=1) with a nonzero `sel_wdata` stores that value in `sel_rd` and sets `lock_rd` on the next cycle.
- R3: When the block is unlocked, a write of 00 changes nothing. `sel_rd` stays 00 and `lock_rd` stays 0.
- R4: When `lock_rd` is 1, every write is ignored and `sel_rd` keeps its value.
- R5: When `sel_rd`=00, `rtc_tick` stays 0.
- R6: When `sel_rd`=01, `rtc_tick` equals `lse_tick` from the previous cycle.
- R7: When `sel_rd`=10, `rtc_tick` equals `lsi_tick` from the previous cycle.
- R8: When `sel_rd`=11, `rtc_tick` pulses for one cycle, in the cycle after every 128th `hse_tick` counted since the prescaler was last reset.
- R9: `div_level` is 0 while the prescaler's count of `hse_tick` pulses is 0 to 63, and 1 while the count is 64 to 127. This gives a 50% duty cycle.
- R10: `rst` or `bkp_rst` sets the prescaler count to zero and drives `rtc_tick` to 0 on the next cycle.
- R11: When `bkp_rst` and a write arrive in the same cycle, `bkp_rst` wins, and the block is left unlocked with 00 selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common fast clock |
| rst | input | 1 | System reset, synchronous, active high |
| bkp_rst | input | 1 | Backup-domain reset, synchronous, active high |
| hse_tick | input | 1 | Enable pulse from the fast crystal clock |
| lse_tick | input | 1 | Enable pulse from the slow crystal clock |
| lsi_tick | input | 1 | Enable pulse from the slow RC clock |
| sel_wr | input | 1 | Write strobe for the select field |
| sel_wdata | input | 2 | Value written to the select field |
| sel_rd | output | 2 | Current select field |
| lock_rd | output | 1 | Lock flag |
| rtc_tick | output | 1 | Registered enable for the real-time counter |
| div_level | output | 1 | 50% duty square wave from the prescaler |

## Verification
The enable inputs are driven with independent random pulse streams while each of the four selections is active. A wrong routing between sources therefore shows up as a mismatch against the reference model. For the prescaler, `hse_tick` is held high continuously in one run and driven sparsely and irregularly in another. This separates counting input pulses from counting clock cycles, and it places the wrap exactly at the 128th pulse. Write sequences are chosen to tell apart a write of zero, a first nonzero write, later writes while locked, and a system reset alone versus a backup-domain reset. One case also applies the backup-domain reset in the same cycle as a write.

// File: rtl/rtcsrc_pkg.sv
package rtcsrc_pkg;
  localparam int SEL_W = 2;
  typedef enum logic [SEL_W-1:0] {
    SRC_NONE = 2'b00,
    SRC_LSE  = 2'b01,
    SRC_LSI  = 2'b10,
    SRC_HSE  = 2'b11
  } rtc_src_e;
endpackage

// File: rtl/rtcsrc_lock.sv
module rtcsrc_lock
  import rtcsrc_pkg::*;
(
  input  logic             clk,
  input  logic             bkp_rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_data,
  output logic [SEL_W-1:0] sel_q,
  output logic             locked_q
);
  // Only the backup-domain reset reaches this register (R1, R11).
  always_ff @(posedge clk) begin
    if (bkp_rst) begin
      sel_q    <= '0;
      locked_q <= 1'b0;
    end else if (wr_en && !locked_q && (wr_data != '0)) begin
      sel_q    <= wr_data;
      locked_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rtcsrc_prescale.sv
module rtcsrc_prescale #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic clr,
  input  logic in_tick,
  output logic out_pulse,
  output logic half_level
);
  localparam int CNT_W = $clog2(DIV);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clr)          cnt_q <= '0;
    else if (in_tick) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign out_pulse  = in_tick && (cnt_q == LAST);
  assign half_level = cnt_q[CNT_W-1];
endmodule

// File: rtl/rtcsrc_mux.sv
module rtcsrc_mux
  import rtcsrc_pkg::*;
(
  input  logic             clk,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  input  logic             lse_en,
  input  logic             lsi_en,
  input  logic             hdiv_en,
  output logic             tick_q
);
  logic pick;

  always_comb begin
    unique case (rtc_src_e'(sel))
      SRC_LSE: pick = lse_en;
      SRC_LSI: pick = lsi_en;
      SRC_HSE: pick = hdiv_en;
      default: pick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (clr) tick_q <= 1'b0;
    else     tick_q <= pick;
  end
endmodule

// File: rtl/rtcsrc_select.sv
module rtcsrc_select
  import rtcsrc_pkg::*;
#(
  parameter int DIV = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bkp_rst,
  input  logic             hse_tick,
  input  logic             lse_tick,
  input  logic             lsi_tick,
  input  logic             sel_wr,
  input  logic [SEL_W-1:0] sel_wdata,
  output logic [SEL_W-1:0] sel_rd,
  output logic             lock_rd,
  output logic             rtc_tick,
  output logic             div_level
);
  logic any_rst;
  logic hdiv_pulse;

  assign any_rst = rst | bkp_rst;

  rtcsrc_lock u_lock (
    .clk      (clk),
    .bkp_rst  (bkp_rst),
    .wr_en    (sel_wr),
    .wr_data  (sel_wdata),
    .sel_q    (sel_rd),
    .locked_q (lock_rd)
  );

  rtcsrc_prescale #(.DIV(DIV)) u_pre (
    .clk        (clk),
    .clr        (any_rst),
    .in_tick    (hse_tick),
    .out_pulse  (hdiv_pulse),
    .half_level (div_level)
  );

  rtcsrc_mux u_mux (
    .clk     (clk),
    .clr     (any_rst),
    .sel     (sel_rd),
    .lse_en  (lse_tick),
    .lsi_en  (lsi_tick),
    .hdiv_en (hdiv_pulse),
    .tick_q  (rtc_tick)
  );
endmodule

// File: rtl/rtcsrc_select_chk.sv
module rtcsrc_select_chk (
  input logic       clk,
  input logic       rst,
  input logic       bkp_rst,
  input logic       lse_tick,
  input logic       lsi_tick,
  input logic       sel_wr,
  input logic [1:0] sel_wdata,
  input logic [1:0] sel_rd,
  input logic       lock_rd,
  input logic       rtc_tick,
  input logic       div_level
);
  a_r1_bkp_clears: assert property (@(posedge clk) disable iff (rst)
    bkp_rst |=> (sel_rd == 2'b00) && !lock_rd);

  a_r2_first_write: assert property (@(posedge clk) disable iff (bkp_rst)
    (sel_wr && !lock_rd && sel_wdata != 2'b00) |=> lock_rd && (sel_rd == $past(sel_wdata)));

  a_r4_locked_hold: assert property (@(posedge clk) disable iff (bkp_rst)
    lock_rd |=> lock_rd && $stable(sel_rd));

  a_r5_none_quiet: assert property (@(posedge clk) disable iff (rst || bkp_rst)
    (sel_rd == 2'b00) |=> !rtc_tick);

  a_r6_lse_follow: assert property (@(posedge clk) disable iff (rst || bkp_rst)
    (sel_rd == 2'b01) |=> rtc_tick == $past(lse_tick));

  a_r7_lsi_follow: assert property (@(posedge clk) disable iff (rst || bkp_rst)
    (sel_rd == 2'b10) |=> rtc_tick == $past(lsi_tick));

  a_r9_wrap_low: assert property (@(posedge clk) disable iff (rst || bkp_rst)
    (rtc_tick && sel_rd == 2'b11) |-> !div_level);

  a_r10_reset_quiet: assert property (@(posedge clk) disable iff (bkp_rst)
    rst |=> !rtc_tick && !div_level);
endmodule

bind rtcsrc_select rtcsrc_select_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bkp_rst   (bkp_rst),
  .lse_tick  (lse_tick),
  .lsi_tick  (lsi_tick),
  .sel_wr    (sel_wr),
  .sel_wdata (sel_wdata),
  .sel_rd    (sel_rd),
  .lock_rd   (lock_rd),
  .rtc_tick  (rtc_tick),
  .div_level (div_level)
);

// File: tb/rtcsrc_select_bench.sv
`timescale 1ns/1ps
module rtcsrc_select_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bkp_rst = 1'b1;
  logic       hse_tick = 1'b0;
  logic       lse_tick = 1'b0;
  logic       lsi_tick = 1'b0;
  logic       sel_wr = 1'b0;
  logic [1:0] sel_wdata = 2'b00;
  logic [1:0] sel_rd;
  logic       lock_rd;
  logic       rtc_tick;
  logic       div_level;

  int n_tests = 0;
  int n_fail  = 0;
  bit cmp_on  = 1'b0;
  bit done    = 1'b0;
  string tag_cfg = "R1";
  string tag_out = "R10";
  int hse_mode = 0;  // 0 random, 1 always, 2 sparse

  // reference model state
  int m_sel = 0, m_lock = 0, m_cnt = 0, m_tick = 0;

  always #4 clk = ~clk;

  rtcsrc_select u_rtcsrc_select (
    .clk(clk), .rst(rst), .bkp_rst(bkp_rst), .hse_tick(hse_tick),
    .lse_tick(lse_tick), .lsi_tick(lsi_tick), .sel_wr(sel_wr),
    .sel_wdata(sel_wdata), .sel_rd(sel_rd), .lock_rd(lock_rd),
    .rtc_tick(rtc_tick), .div_level(div_level)
  );

  always @(posedge clk) begin
    int nxt;
    int wrap;
    wrap = (hse_tick && m_cnt == 127) ? 1 : 0;
    case (m_sel)
      1: nxt = lse_tick;
      2: nxt = lsi_tick;
      3: nxt = wrap;
      default: nxt = 0;
    endcase
    if (rst || bkp_rst) begin
      m_cnt = 0; m_tick = 0;
    end else begin
      m_tick = nxt;
      if (hse_tick) m_cnt = (m_cnt + 1) % 128;
    end
    if (bkp_rst) begin
      m_sel = 0; m_lock = 0;
    end else if (sel_wr && m_lock == 0 && sel_wdata != 0) begin
      m_sel = sel_wdata; m_lock = 1;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check(tag_cfg, "sel_rd", sel_rd, m_sel);
      check(tag_cfg, "lock_rd", lock_rd, m_lock);
      check(tag_out, "rtc_tick", rtc_tick, m_tick);
      check("R9", "div_level", div_level, (m_cnt >= 64) ? 1 : 0);
    end
  end

  // stimulus for enable streams
  int sparse_ph = 0;
  always @(negedge clk) begin
    lse_tick <= ($urandom_range(0, 3) == 0);
    lsi_tick <= ($urandom_range(0, 2) == 0);
    sparse_ph <= (sparse_ph + 1) % 7;
    case (hse_mode)
      1: hse_tick <= 1'b1;
      2: hse_tick <= (sparse_ph == 0 || sparse_ph == 3);
      default: hse_tick <= $urandom_range(0, 1);
    endcase
  end

  task automatic wr(input logic [1:0] v);
    @(negedge clk); sel_wr = 1'b1; sel_wdata = v;
    @(negedge clk); sel_wr = 1'b0; sel_wdata = 2'b00;
  endtask

  task automatic pulse_rst(input bit bkp);
    @(negedge clk);
    if (bkp) bkp_rst = 1'b1; else rst = 1'b1;
    @(negedge clk); rst = 1'b0; bkp_rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0; bkp_rst = 1'b0;
    cmp_on = 1'b1;
    // R1 R10: reset state
    tag_cfg = "R1"; tag_out = "R10";
    @(negedge clk);
    check("R1", "lock after bkp reset", lock_rd, 0);
    // R3 R5: zero write, no source
    tag_cfg = "R3"; tag_out = "R5";
    wr(2'b00);
    repeat (40) @(negedge clk);
    check("R3", "still unlocked", lock_rd, 0);
    // R2 R6: select slow crystal
    tag_cfg = "R2"; tag_out = "R6";
    wr(2'b01);
    check("R2", "sel after write", sel_rd, 1);
    repeat (60) @(negedge clk);
    // R4: locked writes ignored
    tag_cfg = "R4";
    wr(2'b10); wr(2'b11); wr(2'b00);
    check("R4", "sel held", sel_rd, 1);
    repeat (20) @(negedge clk);
    // R1 R10: system reset alone keeps the selection
    tag_cfg = "R1"; tag_out = "R10";
    pulse_rst(1'b0);
    check("R1", "lock kept through rst", lock_rd, 1);
    check("R10", "tick after rst", rtc_tick, 0);
    // R11: backup reset together with a write
    tag_cfg = "R11";
    @(negedge clk); bkp_rst = 1'b1; sel_wr = 1'b1; sel_wdata = 2'b11;
    @(negedge clk); bkp_rst = 1'b0; sel_wr = 1'b0; sel_wdata = 2'b00;
    check("R11", "sel after bkp+write", sel_rd, 0);
    check("R11", "lock after bkp+write", lock_rd, 0);
    // R7: slow RC
    tag_cfg = "R2"; tag_out = "R7";
    wr(2'b10);
    repeat (80) @(negedge clk);
    // R8 R9: divided fast clock, dense then sparse
    tag_cfg = "R1"; tag_out = "R10";
    pulse_rst(1'b1);
    tag_cfg = "R2"; tag_out = "R8";
    hse_mode = 1;
    wr(2'b11);
    repeat (600) @(negedge clk);
    hse_mode = 2;
    pulse_rst(1'b0);
    tag_out = "R8";
    repeat (1500) @(negedge clk);
    hse_mode = 0;
    repeat (500) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule